// File: doc/BRIEF.md
# Per-Line Dark Level Estimator

This block sits on a raw image-sensor pixel stream and produces a black reference for every line. It uses the light-shielded columns at both ends of the line. A line starts with the pixel that carries the start-of-line flag. Each line has four fixed regions, in this order: a few empty pixels that carry no charge, a leading shielded band, the photosensitive columns and a trailing shielded band. The block leaves out the outermost column or columns at each side of both shielded bands, because light leaks into them. It sums the remaining samples and divides by their count with a reciprocal multiply that rounds to nearest. It then presents the mean on a one-cycle strobe.

A second path corrects the image itself. It stores the photosensitive pixels of a line in a line buffer. While the next line streams in, it reads each stored pixel back, subtracts the reference computed for that stored line and saturates the result at zero. The corrected stream therefore runs one line behind the input.

The region sizes and the number of excluded edge columns are elaboration-time parameters, so both reciprocals are constants. A mode input, sampled at the start of each line, selects between two averages: both bands, or the leading band alone. The block has no notion of rows, so shielded rows at the top and bottom of the frame never become a reference unless the surrounding logic feeds them in.

Top module: `dark_level_est`

## Requirements
- R1: While reset is held, dark_valid and clamp_valid are 0 and dark_level is 0.
- R2: The pixel accepted with line_start high is column 0. The first EMPTY_COLS columns never affect the dark level, whatever their values.
- R3: In the leading band (columns EMPTY_COLS to EMPTY_COLS+LEAD_COLS-1), the EDGE_SKIP columns at each side are left out. The remaining columns are summed.
- R4: The trailing band starts right after the ACTIVE_COLS photosensitive columns. The EDGE_SKIP columns at each side are left out and the rest are summed when both bands are in use.
- R5: With lead_only = 0 the result is floor((2*S + N) / (2*N)), which is the mean rounded half up. S is the sum of the used samples and N = LEAD_COLS + TRAIL_COLS - 4*EDGE_SKIP (35 by default).
- R6: With lead_only = 1 only the leading samples are used, with N = LEAD_COLS - 2*EDGE_SKIP (18 by default) and the same rounding. The trailing band has no effect.
- R7: dark_valid is high for exactly one cycle: the cycle after the last used sample of the line is accepted. dark_level holds its value between strobes.
- R8: lead_only is sampled together with the start-of-line pixel. Changing it later in the line has no effect on that line's result.
- R9: Photosensitive column k of line n appears on clamp_data one cycle after column k of line n+1 is accepted. Its value is max(pixel - dark level of line n, 0).
- R10: When the preceding line has produced no dark level (for example the first line after reset), no clamped pixels are emitted.
- R11: Cycles with pix_valid low do not advance the column position and contribute no sample.
- R12: The accumulator holds the sum of all used full-scale samples without overflow, so a line of full-scale samples yields a full-scale dark level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_only | input | 1 | 1: average the leading band only; sampled at line start |
| pix_valid | input | 1 | A pixel is present this cycle |
| line_start | input | 1 | Marks the first pixel of a line (qualified by pix_valid) |
| pix_data | input | PIX_W | Raw pixel code |
| dark_valid | output | 1 | One-cycle strobe: dark_level holds a new result |
| dark_level | output | PIX_W | Rounded mean of the selected shielded samples |
| clamp_valid | output | 1 | A corrected pixel of the previous line is present |
| clamp_data | output | PIX_W | Previous-line pixel minus its dark level, floored at zero |

## Verification
The assertions assume that every line is complete: it starts with the flagged pixel, lines up with the parameterised layout and is at least two pixels long. They also assume that lead_only only matters on the start-of-line pixel. The stimulus sends only full-length lines, inserts idle cycles only between whole pixels, and toggles the mode one pixel after the start flag to show that such a change is ignored. The excluded, empty and trailing columns are loaded with full-scale values so that any leak into the average would show.

// File: rtl/dle_pkg.sv
// Shared types and elaboration-time helpers for the dark level estimator.
// Assumes divisors are small positive integers and shifts stay below 64.
package dle_pkg;

    typedef enum logic {
        AVG_BOTH_BANDS = 1'b0,
        AVG_LEAD_BAND  = 1'b1
    } avg_mode_e;

    // Reciprocal ceil(2^k / d) used for exact floor division by d.
    function automatic logic [63:0] recip_const(input int d, input int k);
        return ((64'd1 << k) + 64'(d) - 64'd1) / 64'(d);
    endfunction

endpackage

// File: rtl/dle_col_tracker.sv
// Column tracker: follows the position inside a line and flags the regions
// the estimator cares about. Column 0 is the pixel flagged by line_start.
// Assumes line_start arrives with pix_valid; pixels before the first
// line_start and beyond the line length belong to no region.
module dle_col_tracker #(
    parameter int EMPTY_COLS  = 4,
    parameter int LEAD_COLS   = 20,
    parameter int ACTIVE_COLS = 4033,
    parameter int TRAIL_COLS  = 19,
    parameter int EDGE_SKIP   = 1,
    localparam int LINE_LEN   = EMPTY_COLS + LEAD_COLS + ACTIVE_COLS + TRAIL_COLS,
    localparam int CW         = $clog2(LINE_LEN + 1),
    localparam int AW         = (ACTIVE_COLS > 1) ? $clog2(ACTIVE_COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          line_start,
    output logic          sol_hit,
    output logic          lead_use,
    output logic          lead_last,
    output logic          trail_use,
    output logic          trail_last,
    output logic          act,
    output logic [AW-1:0] act_idx
);

    localparam int LEAD_LO = EMPTY_COLS + EDGE_SKIP;
    localparam int LEAD_HI = EMPTY_COLS + LEAD_COLS - 1 - EDGE_SKIP;
    localparam int ACT_LO  = EMPTY_COLS + LEAD_COLS;
    localparam int ACT_HI  = ACT_LO + ACTIVE_COLS - 1;
    localparam int TR_LO   = ACT_HI + 1 + EDGE_SKIP;
    localparam int TR_HI   = ACT_HI + TRAIL_COLS - EDGE_SKIP;

    logic [CW-1:0] col;
    logic          in_line;
    logic [CW-1:0] pos;
    logic          here;
    int            p;

    // Position of the current pixel and its region flags.
    always_comb begin
        sol_hit    = pix_valid & line_start;
        pos        = line_start ? '0 : col;
        p          = int'(pos);
        here       = pix_valid & (line_start | in_line) & (p < LINE_LEN);
        lead_use   = here && (p >= LEAD_LO) && (p <= LEAD_HI);
        lead_last  = here && (p == LEAD_HI);
        trail_use  = here && (p >= TR_LO) && (p <= TR_HI);
        trail_last = here && (p == TR_HI);
        act        = here && (p >= ACT_LO) && (p <= ACT_HI);
        act_idx    = AW'(p - ACT_LO);
    end

    // Column counter: restarts at line start, advances on valid pixels only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col     <= '0;
            in_line <= 1'b0;
        end else if (pix_valid) begin
            if (line_start) begin
                col     <= CW'(1);
                in_line <= 1'b1;
            end else if (in_line && (int'(col) < LINE_LEN)) begin
                col <= col + CW'(1);
            end
        end
    end

    // R11: an idle cycle leaves the position untouched.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> $stable(col));

    // R2: a start-of-line pixel puts the next pixel at column 1.
    assert_sol_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && line_start) |=> (col == CW'(1)) && in_line);

endmodule

// File: rtl/dle_dark_accum.sv
// Dark accumulator: sums the selected shielded samples of a line, divides by
// the sample count with a constant reciprocal (round half up) and strobes the
// result one cycle after the last used sample. The mode is captured at line
// start. Assumes each line is complete and at least two pixels long.
module dle_dark_accum
    import dle_pkg::*;
#(
    parameter int PIX_W  = 14,
    parameter int N_ALL  = 35,
    parameter int N_LEAD = 18,
    localparam int ACC_W = PIX_W + $clog2(N_ALL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             sol_hit,
    input  logic             lead_only,
    input  logic             lead_use,
    input  logic             lead_last,
    input  logic             trail_use,
    input  logic             trail_last,
    input  logic [PIX_W-1:0] pix_data,
    output logic             dark_valid,
    output logic [PIX_W-1:0] dark_level
);

    localparam logic [ACC_W-1:0] ACC_MAX = ACC_W'(N_ALL * ((1 << PIX_W) - 1));

    avg_mode_e        mode_q;
    avg_mode_e        mode_cur;
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum_next;
    logic             take;
    logic             fin;
    logic [PIX_W-1:0] quot [2];

    // Selects this pixel as a sample and forms the running sum.
    always_comb begin
        mode_cur = sol_hit ? avg_mode_e'(lead_only) : mode_q;
        take     = lead_use | (trail_use & (mode_cur == AVG_BOTH_BANDS));
        fin      = (mode_cur == AVG_LEAD_BAND) ? lead_last : trail_last;
        sum_next = (sol_hit ? '0 : acc) + (take ? ACC_W'(pix_data) : '0);
    end

    // One rounding divider per averaging mode, each with its own constant.
    for (genvar g = 0; g < 2; g++) begin : g_div
        localparam int  NS   = (g == 0) ? N_ALL : N_LEAD;
        localparam int  DEN  = 2 * NS;
        localparam longint XMAX = longint'(DEN) * longint'((1 << PIX_W) - 1) + longint'(NS);
        localparam int  XB   = $clog2(XMAX + 1);
        localparam int  SH   = XB + $clog2(DEN) + 1;
        localparam logic [63:0] MUL = recip_const(DEN, SH);
        logic [63:0] num;
        logic [63:0] prod;

        // floor((2S+N)/(2N)) through multiply and shift.
        always_comb begin
            num     = (64'(sum_next) << 1) + 64'(NS);
            prod    = num * MUL;
            quot[g] = PIX_W'(prod >> SH);
        end
    end

    // Accumulator, captured mode and the result strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc        <= '0;
            mode_q     <= AVG_BOTH_BANDS;
            dark_valid <= 1'b0;
            dark_level <= '0;
        end else begin
            if (sol_hit) mode_q <= mode_cur;
            if (sol_hit || take) acc <= sum_next;
            dark_valid <= fin;
            if (fin) dark_level <= quot[mode_cur];
        end
    end

    assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        acc <= ACC_MAX);

    assert_strobe_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dark_valid |=> !dark_valid);

    assert_strobe_after_pixel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dark_valid |-> $past(pix_valid));

    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dark_valid |-> $stable(dark_level));

endmodule

// File: rtl/dle_line_clamp.sv
// Line clamp: keeps the photosensitive pixels of one line and, while the next
// line arrives, emits each stored pixel minus the dark level of its own line,
// floored at zero. The reference is latched at line start so that a result
// computed early in the new line does not reach the old line's pixels.
module dle_line_clamp #(
    parameter int PIX_W       = 14,
    parameter int ACTIVE_COLS = 4033,
    localparam int AW         = (ACTIVE_COLS > 1) ? $clog2(ACTIVE_COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sol_hit,
    input  logic             act,
    input  logic [AW-1:0]    act_idx,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             dark_valid,
    input  logic [PIX_W-1:0] dark_level,
    output logic             clamp_valid,
    output logic [PIX_W-1:0] clamp_data
);

    logic [PIX_W-1:0] line_mem [ACTIVE_COLS];
    logic [PIX_W-1:0] old_pix;
    logic [PIX_W-1:0] ref_dark;
    logic             ref_ok;
    logic             line_done;

    // Stored pixel of the previous line at this column.
    always_comb old_pix = line_mem[act_idx];

    // Line buffer write: replaces the old pixel after it has been read.
    always_ff @(posedge clk) begin
        if (act) line_mem[act_idx] <= pix_data;
    end

    // Reference latch and the corrected output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_dark    <= '0;
            ref_ok      <= 1'b0;
            line_done   <= 1'b0;
            clamp_valid <= 1'b0;
            clamp_data  <= '0;
        end else begin
            if (sol_hit) begin
                ref_dark  <= dark_level;
                ref_ok    <= line_done | dark_valid;
                line_done <= 1'b0;
            end else if (dark_valid) begin
                line_done <= 1'b1;
            end
            clamp_valid <= act & ref_ok;
            clamp_data  <= (old_pix > ref_dark) ? (old_pix - ref_dark) : '0;
        end
    end

    assert_clamp_after_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clamp_valid |-> $past(act));

    assert_no_clamp_before_ref_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sol_hit && !line_done && !dark_valid) |=> !ref_ok);

endmodule

// File: rtl/dark_level_est.sv
// Per-line dark level estimator top: ties the column tracker, the dark
// accumulator and the one-line-delayed clamp together. The layout of a line
// (empty, leading band, photosensitive, trailing band) is fixed by parameters.
module dark_level_est #(
    parameter int PIX_W       = 14,
    parameter int EMPTY_COLS  = 4,
    parameter int LEAD_COLS   = 20,
    parameter int ACTIVE_COLS = 4033,
    parameter int TRAIL_COLS  = 19,
    parameter int EDGE_SKIP   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lead_only,
    input  logic             pix_valid,
    input  logic             line_start,
    input  logic [PIX_W-1:0] pix_data,
    output logic             dark_valid,
    output logic [PIX_W-1:0] dark_level,
    output logic             clamp_valid,
    output logic [PIX_W-1:0] clamp_data
);

    localparam int N_LEAD = LEAD_COLS - 2 * EDGE_SKIP;
    localparam int N_ALL  = N_LEAD + TRAIL_COLS - 2 * EDGE_SKIP;
    localparam int AW     = (ACTIVE_COLS > 1) ? $clog2(ACTIVE_COLS) : 1;

    logic          sol_hit;
    logic          lead_use;
    logic          lead_last;
    logic          trail_use;
    logic          trail_last;
    logic          act;
    logic [AW-1:0] act_idx;

    dle_col_tracker #(
        .EMPTY_COLS (EMPTY_COLS),
        .LEAD_COLS  (LEAD_COLS),
        .ACTIVE_COLS(ACTIVE_COLS),
        .TRAIL_COLS (TRAIL_COLS),
        .EDGE_SKIP  (EDGE_SKIP)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .line_start(line_start),
        .sol_hit   (sol_hit),
        .lead_use  (lead_use),
        .lead_last (lead_last),
        .trail_use (trail_use),
        .trail_last(trail_last),
        .act       (act),
        .act_idx   (act_idx)
    );

    dle_dark_accum #(
        .PIX_W (PIX_W),
        .N_ALL (N_ALL),
        .N_LEAD(N_LEAD)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_valid (pix_valid),
        .sol_hit   (sol_hit),
        .lead_only (lead_only),
        .lead_use  (lead_use),
        .lead_last (lead_last),
        .trail_use (trail_use),
        .trail_last(trail_last),
        .pix_data  (pix_data),
        .dark_valid(dark_valid),
        .dark_level(dark_level)
    );

    dle_line_clamp #(
        .PIX_W      (PIX_W),
        .ACTIVE_COLS(ACTIVE_COLS)
    ) u_clamp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sol_hit    (sol_hit),
        .act        (act),
        .act_idx    (act_idx),
        .pix_data   (pix_data),
        .dark_valid (dark_valid),
        .dark_level (dark_level),
        .clamp_valid(clamp_valid),
        .clamp_data (clamp_data)
    );

    // R1: outputs stay quiet during reset.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !dark_valid && !clamp_valid && (dark_level == '0));

endmodule

// File: tb/dark_level_est_test.sv
// Scoreboard bench: the line driver predicts dark levels and clamped pixels
// (value and cycle) into queues; a monitor pops and compares them.
module dark_level_est_test;

    localparam int W    = 14;
    localparam int E    = 4;
    localparam int L    = 20;
    localparam int A    = 24;
    localparam int T    = 19;
    localparam int X    = 1;
    localparam int LEN  = E + L + A + T;
    localparam int LLO  = E + X;
    localparam int LHI  = E + L - 1 - X;
    localparam int ALO  = E + L;
    localparam int TLO  = E + L + A + X;
    localparam int THI  = E + L + A + T - 1 - X;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         lead_only = 1'b0;
    logic         pix_valid = 1'b0;
    logic         line_start = 1'b0;
    logic [W-1:0] pix_data = '0;
    logic         dark_valid;
    logic [W-1:0] dark_level;
    logic         clamp_valid;
    logic [W-1:0] clamp_data;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    int    line_px [LEN];
    int    prev_act [A];
    int    prev_dark = 0;
    bit    prev_ok = 1'b0;
    int    dq_val[$];
    int    dq_cyc[$];
    string dq_tag[$];
    int    cq_val[$];
    int    cq_cyc[$];

    dark_level_est #(
        .PIX_W(W), .EMPTY_COLS(E), .LEAD_COLS(L),
        .ACTIVE_COLS(A), .TRAIL_COLS(T), .EDGE_SKIP(X)
    ) uut (
        .clk(clk), .rst_n(rst_n), .lead_only(lead_only), .pix_valid(pix_valid),
        .line_start(line_start), .pix_data(pix_data), .dark_valid(dark_valid),
        .dark_level(dark_level), .clamp_valid(clamp_valid), .clamp_data(clamp_data)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Layout helper: fills each region of line_px with the given values.
    task automatic fill(input int empty_v, input int edge_v, input int lead_v,
                        input int trail_v, input int act_max);
        for (int j = 0; j < LEN; j++) begin
            if (j < E) line_px[j] = empty_v;
            else if (j < ALO) line_px[j] = (j < LLO || j > LHI) ? edge_v : lead_v;
            else if (j < ALO + A) line_px[j] = int'($urandom_range(0, act_max));
            else line_px[j] = (j < TLO || j > THI) ? edge_v : trail_v;
        end
    endtask

    task automatic rand_dark();
        for (int j = LLO; j <= LHI; j++) line_px[j] = int'($urandom_range(0, 3000));
        for (int j = TLO; j <= THI; j++) line_px[j] = int'($urandom_range(0, 3000));
    endtask

    // Drives one line and predicts every output it causes.
    task automatic send_line(input bit mode, input bit flip, input int gap_at,
                             input string tag);
        int sum = 0;
        int n;
        int dk;
        int last;
        for (int j = 0; j < LEN; j++) begin
            if ((j >= LLO && j <= LHI) || (!mode && j >= TLO && j <= THI))
                sum += line_px[j];
        end
        n    = mode ? (LHI - LLO + 1) : (LHI - LLO + 1) + (THI - TLO + 1);
        dk   = (2 * sum + n) / (2 * n);
        last = mode ? LHI : THI;
        for (int j = 0; j < LEN; j++) begin
            @(negedge clk);
            if (j == gap_at) begin
                pix_valid = 1'b0;
                line_start = 1'b0;
                @(negedge clk);
                @(negedge clk);
            end
            pix_valid  = 1'b1;
            line_start = (j == 0);
            pix_data   = W'(line_px[j]);
            if (j == 0) lead_only = mode;
            if (j == 1 && flip) lead_only = ~mode;
            if (j == last) begin
                dq_val.push_back(dk);
                dq_cyc.push_back(cyc + 1);
                dq_tag.push_back(tag);
            end
            if (j >= ALO && j < ALO + A && prev_ok) begin
                cq_val.push_back(prev_act[j - ALO] > prev_dark ?
                                 prev_act[j - ALO] - prev_dark : 0);
                cq_cyc.push_back(cyc + 1);
            end
        end
        for (int k = 0; k < A; k++) prev_act[k] = line_px[ALO + k];
        prev_dark = dk;
        prev_ok   = 1'b1;
        @(negedge clk);
        pix_valid  = 1'b0;
        line_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: compares strobes and clamped pixels against the queues.
    always @(negedge clk) begin
        if (mon_on) begin
            if (dq_cyc.size() > 0 && dq_cyc[0] < cyc) begin
                check("R7 missing strobe", 0, 1);
                void'(dq_val.pop_front());
                void'(dq_cyc.pop_front());
                void'(dq_tag.pop_front());
            end
            if (dark_valid) begin
                if (dq_val.size() == 0) begin
                    check("R7 unexpected strobe", int'(dark_level), -1);
                end else begin
                    check(dq_tag.pop_front(), int'(dark_level), dq_val.pop_front());
                    check("R7 strobe cycle", cyc, dq_cyc.pop_front());
                end
            end
            if (cq_cyc.size() > 0 && cq_cyc[0] < cyc) begin
                check("R9 missing clamp pixel", 0, 1);
                void'(cq_val.pop_front());
                void'(cq_cyc.pop_front());
            end
            if (clamp_valid) begin
                if (cq_val.size() == 0) begin
                    check("R10 unexpected clamp pixel", int'(clamp_data), -1);
                end else begin
                    check("R9 clamp value", int'(clamp_data), cq_val.pop_front());
                    check("R9 clamp cycle", cyc, cq_cyc.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        check("R1 dark_valid", int'(dark_valid), 0);
        check("R1 clamp_valid", int'(clamp_valid), 0);
        check("R1 dark_level", int'(dark_level), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // First line: R5 random bands; R10 no clamp output for it.
        fill(0, 0, 0, 0, MAXV);
        rand_dark();
        send_line(1'b0, 1'b0, -1, "R5 random both bands");

        // R11: idle cycles in the middle of the photosensitive region.
        fill(0, 0, 0, 0, MAXV);
        rand_dark();
        send_line(1'b0, 1'b0, 30, "R11 gapped line");

        // R2, R3, R4: empty and edge columns full scale, used samples 500.
        fill(MAXV, MAXV, 500, 500, 1000);
        send_line(1'b0, 1'b0, -1, "R3 R4 edge exclusion");

        // R12: full scale everywhere; clamp of previous line floors at zero.
        fill(MAXV, MAXV, MAXV, MAXV, MAXV);
        send_line(1'b0, 1'b0, 10, "R12 full scale");

        // R6: leading band only, trailing band full scale.
        fill(0, MAXV, 200, MAXV, 4000);
        send_line(1'b1, 1'b0, -1, "R6 lead only");

        // R8: mode flipped after the start pixel must be ignored.
        fill(0, MAXV, 300, 900, 4000);
        send_line(1'b0, 1'b1, -1, "R8 mode captured at start");

        // R5 rounding: 3517/35 rounds down, 3518/35 rounds up.
        fill(0, MAXV, 100, 100, 4000);
        line_px[LLO] = 117;
        send_line(1'b0, 1'b0, -1, "R5 round down");
        fill(0, MAXV, 100, 100, 4000);
        line_px[THI] = 118;
        send_line(1'b0, 1'b0, -1, "R5 round up");

        // R6 rounding: 909/18 is exactly half, rounds up to 51.
        fill(0, MAXV, 50, MAXV, 4000);
        line_px[LHI] = 59;
        send_line(1'b1, 1'b1, -1, "R6 half rounds up");

        fill(0, 0, 0, 0, MAXV);
        rand_dark();
        send_line(1'b0, 1'b0, -1, "R5 final line");

        repeat (5) @(negedge clk);
        check("R7 pending strobes", dq_val.size(), 0);
        check("R9 pending clamp pixels", cq_val.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule